// File: doc/BRIEF.md
# Event-Frozen Record Capture Buffer

This block keeps a rolling history of monitor log records in a circular memory. Every record carries a free-running timestamp, the unfiltered phase sample, the decision-path value, the alarm state, and the decision-layer state: the persistence count, the hysteresis state and the blanking flag. It also carries a marker bit and an event-type code. While the buffer is armed, new records overwrite the oldest ones without pause.

A step, burst or switch event arrives as a one-cycle pulse with a type code. The block marks the matching record and then accepts a programmed number of further records. After that it stops writing and raises its frozen flag. The retained records are the history before the event, the event itself, and the post-event tail. A reader then pulls them out one per request, oldest first.

Events that arrive while a capture is already in progress are counted and otherwise ignored. An unfreeze pulse re-arms the buffer, and writing continues at the slot where it stopped.

Top module: `evt_ring_logger`

## Requirements
- R1: A timestamp counter is 0 during reset and advances by one on every clock after it. Each stored record holds the counter value of the cycle in which it was written.
- R2: While not frozen, each cycle with `rec_valid` high writes one record into the next slot. The slots wrap modulo DEPTH, so the oldest record is overwritten once the memory is full.
- R3: A record read back returns unchanged the raw phase, the decision value, the alarm state, the persistence count, the hysteresis bit and the blanking bit that were written.
- R4: An event pulse while armed marks one record: the record written in the same cycle, or else the next record written. The mark is a marker bit of 1 plus the 2-bit type sampled with the accepted pulse. `evt_index` reports the slot of the marked record and `evt_code` reports the accepted type.
- R5: `post_len` is sampled when the event is accepted. Exactly that many records are written after the marked record. `frozen` rises on the clock edge of the last of them, or on the edge of the marked write itself when the count is 0.
- R6: While frozen, `rec_valid` is ignored and `frozen` stays high until an unfreeze pulse.
- R7: An event pulse that arrives while a mark is pending, while the post count runs, or while frozen does not retrigger and adds no marker. It increments `missed_cnt`, which saturates at all ones.
- R8: While frozen, each `rd_req` returns the next retained record on the clock edge that samples it, with `rd_valid` high. The order runs oldest first, starting from the write pointer minus the fill. The fill is the number of writes since reset, capped at DEPTH. `rd_last` marks the final record. Requests past the end, or made while not frozen, give `rd_valid` low.
- R9: An unfreeze pulse while frozen clears `frozen` and re-arms the event input. Writing resumes at the slot after the last record written, and the next readout starts from the new oldest record.
- R10: After reset `frozen`, `rd_valid` and `missed_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | A record is presented this cycle |
| rec_raw | input | PHASE_W | Unfiltered phase sample |
| rec_dec | input | PHASE_W | Decision-path value |
| rec_alarm | input | ALARM_W | Alarm state |
| rec_persist | input | PERS_W | Persistence counter value |
| rec_hyst | input | 1 | Hysteresis state |
| rec_blank | input | 1 | Blanking active |
| evt_pulse | input | 1 | Event strobe |
| evt_type | input | TYPE_W | Event type code |
| post_len | input | AW+1 | Records to keep after the marked one |
| unfreeze | input | 1 | Release a frozen capture |
| rd_req | input | 1 | Read the next retained record |
| frozen | output | 1 | Capture complete, writes stopped |
| evt_index | output | AW | Slot of the marked record |
| evt_code | output | TYPE_W | Type of the accepted event |
| missed_cnt | output | MISS_W | Saturating count of ignored events |
| rd_valid | output | 1 | Read data valid |
| rd_last | output | 1 | Final retained record |
| rd_ts | output | TS_W | Timestamp of read record |
| rd_raw | output | PHASE_W | Raw phase of read record |
| rd_dec | output | PHASE_W | Decision value of read record |
| rd_alarm | output | ALARM_W | Alarm state of read record |
| rd_persist | output | PERS_W | Persistence count of read record |
| rd_hyst | output | 1 | Hysteresis bit of read record |
| rd_blank | output | 1 | Blanking bit of read record |
| rd_marker | output | 1 | Record is the event record |
| rd_evt_type | output | TYPE_W | Type stored with the record |

## Verification
A wrong write pointer or fill value first becomes visible at readout. The records then come back out of order, with gaps in the timestamps, or with a count that differs from the writes. A fault in the post counter moves the rising edge of `frozen` by whole cycles against the last post-event write, so sampling `frozen` just before and just after that write catches it at once. A broken mark or retrigger rule shows on `evt_index`, on the position of the single marker within the readout, or on `missed_cnt`, as soon as the capture is frozen.

// File: rtl/elog_pkg.sv
package elog_pkg;

  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_PEND   = 2'd1,
    ST_POST   = 2'd2,
    ST_FROZEN = 2'd3
  } cap_state_e;

endpackage

// File: rtl/elog_tstamp.sv
module elog_tstamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts
);

  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= ts + TS_W'(1);
  end

  AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ts == $past(ts) + TS_W'(1)); // R1

endmodule

// File: rtl/elog_ram.sv
module elog_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  q
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[ra];
  end

endmodule

// File: rtl/elog_ctrl.sv
module elog_ctrl
  import elog_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TYPE_W = 2,
  parameter int MISS_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_valid,
  input  logic              evt_pulse,
  input  logic [TYPE_W-1:0] evt_type,
  input  logic [CW-1:0]     post_len,
  input  logic              unfreeze,
  input  logic              rd_req,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              wr_mark,
  output logic [TYPE_W-1:0] wr_mtype,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              rd_final,
  output logic              frozen,
  output logic [AW-1:0]     evt_index,
  output logic [TYPE_W-1:0] evt_code,
  output logic [MISS_W-1:0] missed_cnt
);

  cap_state_e        state;
  logic [AW-1:0]     wp;
  logic [CW-1:0]     fill;
  logic [CW-1:0]     post_q;
  logic [CW-1:0]     cnt;
  logic [TYPE_W-1:0] pend_type;
  logic [AW-1:0]     rd_ptr;
  logic [CW-1:0]     rd_left;

  logic              accept;
  logic [CW-1:0]     eff_post;
  logic [AW-1:0]     wp_nx;
  logic [CW-1:0]     fill_nx;
  logic              freeze_now;
  logic              miss_hit;

  // write side
  always_comb begin
    accept   = evt_pulse && (state == ST_ARMED);
    miss_hit = evt_pulse && (state != ST_ARMED);
    wr_en    = rec_valid && (state != ST_FROZEN);
    wr_addr  = wp;
    wr_mark  = wr_en && ((state == ST_PEND) || accept);
    wr_mtype = (state == ST_PEND) ? pend_type : evt_type;
    eff_post = (state == ST_PEND) ? post_q : post_len;
    wp_nx    = wr_en ? wp + AW'(1) : wp;
    if (wr_en && (fill != CW'(DEPTH))) fill_nx = fill + CW'(1);
    else                               fill_nx = fill;
    freeze_now = (wr_mark && (eff_post == '0)) ||
                 ((state == ST_POST) && wr_en && (cnt == CW'(1)));
  end

  // read side
  always_comb begin
    rd_en    = (state == ST_FROZEN) && rd_req && !unfreeze && (rd_left != '0);
    rd_addr  = rd_ptr;
    rd_final = (rd_left == CW'(1));
    frozen   = (state == ST_FROZEN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ARMED;
      wp        <= '0;
      fill      <= '0;
      post_q    <= '0;
      cnt       <= '0;
      pend_type <= '0;
      evt_index <= '0;
      evt_code  <= '0;
      rd_ptr    <= '0;
      rd_left   <= '0;
    end else begin
      wp   <= wp_nx;
      fill <= fill_nx;
      if (accept) begin
        post_q    <= post_len;
        pend_type <= evt_type;
        evt_code  <= evt_type;
      end
      if (wr_mark) evt_index <= wp;

      if (freeze_now) begin
        state   <= ST_FROZEN;
        rd_ptr  <= wp_nx - fill_nx[AW-1:0];
        rd_left <= fill_nx;
      end else begin
        unique case (state)
          ST_ARMED: begin
            if (wr_mark) begin
              state <= ST_POST;
              cnt   <= eff_post;
            end else if (accept) begin
              state <= ST_PEND;
            end
          end
          ST_PEND: begin
            if (wr_mark) begin
              state <= ST_POST;
              cnt   <= eff_post;
            end
          end
          ST_POST: begin
            if (wr_en) cnt <= cnt - CW'(1);
          end
          ST_FROZEN: begin
            if (unfreeze) begin
              state   <= ST_ARMED;
              rd_left <= '0;
            end else if (rd_en) begin
              rd_ptr  <= rd_ptr + AW'(1);
              rd_left <= rd_left - CW'(1);
            end
          end
          default: state <= ST_ARMED;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                            missed_cnt <= '0;
    else if (miss_hit && (missed_cnt != {MISS_W{1'b1}})) missed_cnt <= missed_cnt + MISS_W'(1);
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH)); // R2
  AST_WP_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    state == ST_FROZEN |=> wp == $past(wp)); // R6
  AST_FROZEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FROZEN) && !unfreeze |=> state == ST_FROZEN); // R6
  AST_POST_TO_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POST) && wr_en && (cnt == CW'(1)) |=> state == ST_FROZEN); // R5
  AST_MARK_ONCE: assert property (@(posedge clk) disable iff (rst)
    wr_mark |=> (state == ST_POST) || (state == ST_FROZEN)); // R4
  AST_MISS_INC: assert property (@(posedge clk) disable iff (rst)
    miss_hit && (missed_cnt != {MISS_W{1'b1}}) |=> missed_cnt == $past(missed_cnt) + MISS_W'(1)); // R7
  AST_RD_LEFT_BOUND: assert property (@(posedge clk) disable iff (rst)
    rd_left <= fill); // R8

endmodule

// File: rtl/evt_ring_logger.sv
module evt_ring_logger #(
  parameter int DEPTH   = 16,
  parameter int TS_W    = 32,
  parameter int PHASE_W = 16,
  parameter int ALARM_W = 2,
  parameter int PERS_W  = 4,
  parameter int TYPE_W  = 2,
  parameter int MISS_W  = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = AW + 1,
  localparam int REC_W  = TS_W + 2 * PHASE_W + ALARM_W + PERS_W + 3 + TYPE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rec_valid,
  input  logic [PHASE_W-1:0] rec_raw,
  input  logic [PHASE_W-1:0] rec_dec,
  input  logic [ALARM_W-1:0] rec_alarm,
  input  logic [PERS_W-1:0]  rec_persist,
  input  logic               rec_hyst,
  input  logic               rec_blank,
  input  logic               evt_pulse,
  input  logic [TYPE_W-1:0]  evt_type,
  input  logic [CW-1:0]      post_len,
  input  logic               unfreeze,
  input  logic               rd_req,
  output logic               frozen,
  output logic [AW-1:0]      evt_index,
  output logic [TYPE_W-1:0]  evt_code,
  output logic [MISS_W-1:0]  missed_cnt,
  output logic               rd_valid,
  output logic               rd_last,
  output logic [TS_W-1:0]    rd_ts,
  output logic [PHASE_W-1:0] rd_raw,
  output logic [PHASE_W-1:0] rd_dec,
  output logic [ALARM_W-1:0] rd_alarm,
  output logic [PERS_W-1:0]  rd_persist,
  output logic               rd_hyst,
  output logic               rd_blank,
  output logic               rd_marker,
  output logic [TYPE_W-1:0]  rd_evt_type
);

  logic [TS_W-1:0]   ts_now;
  logic              wr_en, wr_mark, rd_en, rd_final;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [TYPE_W-1:0] wr_mtype;
  logic [REC_W-1:0]  wr_word, rd_word;

  elog_tstamp #(.TS_W(TS_W)) u_ts (
    .clk (clk),
    .rst (rst),
    .ts  (ts_now)
  );

  elog_ctrl #(.DEPTH(DEPTH), .TYPE_W(TYPE_W), .MISS_W(MISS_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rec_valid  (rec_valid),
    .evt_pulse  (evt_pulse),
    .evt_type   (evt_type),
    .post_len   (post_len),
    .unfreeze   (unfreeze),
    .rd_req     (rd_req),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_mark    (wr_mark),
    .wr_mtype   (wr_mtype),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_final   (rd_final),
    .frozen     (frozen),
    .evt_index  (evt_index),
    .evt_code   (evt_code),
    .missed_cnt (missed_cnt)
  );

  assign wr_word = {ts_now, rec_raw, rec_dec, rec_alarm, rec_persist,
                    rec_hyst, rec_blank, wr_mark, wr_mark ? wr_mtype : {TYPE_W{1'b0}}};

  elog_ram #(.DEPTH(DEPTH), .W(REC_W)) u_ram (
    .clk (clk),
    .we  (wr_en),
    .wa  (wr_addr),
    .wd  (wr_word),
    .re  (rd_en),
    .ra  (rd_addr),
    .q   (rd_word)
  );

  assign {rd_ts, rd_raw, rd_dec, rd_alarm, rd_persist,
          rd_hyst, rd_blank, rd_marker, rd_evt_type} = rd_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_last  <= rd_en && rd_final;
    end
  end

  AST_RD_ONLY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(frozen)); // R8
  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid); // R8

endmodule

// File: tb/tb_evt_ring_logger.sv
module tb_evt_ring_logger;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int MISS_W = 3;
  localparam int MISS_MAX = (1 << MISS_W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rec_valid = 1'b0;
  logic [15:0] rec_raw = '0, rec_dec = '0;
  logic [1:0]  rec_alarm = '0;
  logic [3:0]  rec_persist = '0;
  logic        rec_hyst = 1'b0, rec_blank = 1'b0;
  logic        evt_pulse = 1'b0;
  logic [1:0]  evt_type = '0;
  logic [3:0]  post_len = '0;
  logic        unfreeze = 1'b0, rd_req = 1'b0;

  logic        frozen, rd_valid, rd_last, rd_hyst, rd_blank, rd_marker;
  logic [2:0]  evt_index;
  logic [1:0]  evt_code, rd_alarm, rd_evt_type;
  logic [2:0]  missed_cnt;
  logic [31:0] rd_ts;
  logic [15:0] rd_raw, rd_dec;
  logic [3:0]  rd_persist;

  evt_ring_logger #(.DEPTH(DEPTH), .MISS_W(MISS_W)) dut (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_raw(rec_raw), .rec_dec(rec_dec),
    .rec_alarm(rec_alarm), .rec_persist(rec_persist), .rec_hyst(rec_hyst),
    .rec_blank(rec_blank), .evt_pulse(evt_pulse), .evt_type(evt_type),
    .post_len(post_len), .unfreeze(unfreeze), .rd_req(rd_req), .frozen(frozen),
    .evt_index(evt_index), .evt_code(evt_code), .missed_cnt(missed_cnt),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_ts(rd_ts), .rd_raw(rd_raw),
    .rd_dec(rd_dec), .rd_alarm(rd_alarm), .rd_persist(rd_persist), .rd_hyst(rd_hyst),
    .rd_blank(rd_blank), .rd_marker(rd_marker), .rd_evt_type(rd_evt_type)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] cyc;
  always_ff @(posedge clk) cyc <= rst ? 32'd0 : cyc + 32'd1;

  int total = 0, bad = 0;
  int stored = 0, exp_missed = 0, mark_seq = 0, mark_type = 0;
  logic [31:0] ts_arr [0:1023];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] f_raw(int s); return 16'(s * 37 + 5); endfunction
  function automatic logic [15:0] f_dec(int s); return 16'(s) ^ 16'h5A5A; endfunction
  function automatic logic [6:0] f_state(int s);
    logic [31:0] v = 32'(s);
    return {v[1:0], v[4:1], v[0] ^ v[2], v[1]};
  endfunction

  task automatic put_rec(int s);
    rec_valid = 1'b1;
    rec_raw = f_raw(s);
    rec_dec = f_dec(s);
    {rec_alarm, rec_persist, rec_hyst, rec_blank} = f_state(s);
  endtask

  task automatic store_write();
    put_rec(stored);
    ts_arr[stored] = cyc;
    stored++;
  endtask

  task automatic run_case(int pre, int p, int ty, bit same, bit probe_rd);
    int fill;
    for (int i = 0; i < pre; i++) begin
      store_write();
      rd_req = probe_rd;
      @(negedge clk);
      if (probe_rd) chk(rd_valid == 1'b0, "R8 read while armed", rd_valid, 0);
    end
    rd_req = 1'b0;
    evt_pulse = 1'b1; evt_type = 2'(ty); post_len = 4'(p); mark_type = ty;
    if (same) begin
      mark_seq = stored;
      store_write();
      @(negedge clk);
    end else begin
      rec_valid = 1'b0;
      @(negedge clk);
      evt_type = 2'(ty ^ 1);           // second pulse while pending: missed
      exp_missed++;
      mark_seq = stored;
      store_write();
      @(negedge clk);
    end
    evt_pulse = 1'b0;
    post_len = 4'(p + 3);              // must have been latched at acceptance
    for (int k = 0; k < p; k++) begin
      chk(frozen == 1'b0, "R5 frozen early", frozen, 0);
      if (k == 0) begin evt_pulse = 1'b1; exp_missed++; end
      store_write();
      @(negedge clk);
      evt_pulse = 1'b0;
    end
    chk(frozen == 1'b1, "R5 frozen after post count", frozen, 1);
    for (int j = 0; j < 3; j++) begin  // dropped records, one event while frozen
      put_rec(900 + j);
      evt_pulse = (j == 1);
      if (j == 1) exp_missed++;
      @(negedge clk);
    end
    rec_valid = 1'b0; evt_pulse = 1'b0;
    chk(frozen == 1'b1, "R6 frozen holds", frozen, 1);
    chk(evt_index == 3'(mark_seq % DEPTH), "R4 evt_index", evt_index, mark_seq % DEPTH);
    chk(evt_code == 2'(ty), "R4 evt_code", evt_code, ty);
    chk(int'(missed_cnt) == ((exp_missed > MISS_MAX) ? MISS_MAX : exp_missed),
        "R7 missed_cnt", missed_cnt, (exp_missed > MISS_MAX) ? MISS_MAX : exp_missed);
    fill = (stored > DEPTH) ? DEPTH : stored;
    rd_req = 1'b1;
    for (int i = 0; i < fill; i++) begin
      int s;
      s = stored - fill + i;
      @(negedge clk);
      chk(rd_valid == 1'b1, "R8 rd_valid", rd_valid, 1);
      chk(rd_ts == ts_arr[s], "R1 timestamp", rd_ts, ts_arr[s]);
      chk(rd_raw == f_raw(s) && rd_dec == f_dec(s), "R2 R3 phase values", rd_raw, f_raw(s));
      chk({rd_alarm, rd_persist, rd_hyst, rd_blank} == f_state(s), "R3 decision state",
          {rd_alarm, rd_persist, rd_hyst, rd_blank}, f_state(s));
      chk(rd_marker == (s == mark_seq), "R4 marker", rd_marker, s == mark_seq);
      if (s == mark_seq) chk(rd_evt_type == 2'(mark_type), "R4 stored type", rd_evt_type, mark_type);
      chk(rd_last == (i == fill - 1), "R8 rd_last", rd_last, i == fill - 1);
    end
    @(negedge clk);
    chk(rd_valid == 1'b0, "R8 read past end", rd_valid, 0);
    rd_req = 1'b0;
    unfreeze = 1'b1;
    @(negedge clk);
    unfreeze = 1'b0;
    chk(frozen == 1'b0, "R9 unfreeze", frozen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(frozen == 1'b0, "R10 reset frozen", frozen, 0);
    chk(rd_valid == 1'b0, "R10 reset rd_valid", rd_valid, 0);
    chk(missed_cnt == 3'd0, "R10 reset missed", missed_cnt, 0);
    chk(cyc == 32'd0, "R1 bench time base", cyc, 0);
    for (int p = 0; p <= DEPTH; p++) begin
      int pre;
      pre = (p == 0) ? 2 : ((p * 3) % 7 + 4);
      run_case(pre, p, p % 4, (p % 2) == 0, p == 0);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule